// File: doc/BRIEF.md
# End-of-Interrupt Broadcast Handler with Storm Throttle

This block takes an end-of-interrupt (EOI) vector and checks every interrupt pin's redirection entry against it in a single cycle. A pin takes part when its trigger mode is level, its vector field equals the EOI vector, and its remote-IRR flag is set. For each such pin the block raises a one-cycle strobe that clears remote IRR in the entry storage, which lives outside this block. It then decides whether the pin must be delivered again. The register file supplies the entry fields and the raw IRR bits as flat input vectors. The delivery sequencer receives a single re-service request.

Each pin has a counter of back-to-back reasserts. A reassert happens when an EOI finds the pin unmasked with its IRR bit still high. If the incremented count stays below the storm limit, the block requests an immediate re-service. If it reaches the limit, the counter returns to zero and a delay timer starts instead, by default 10 ms worth of clock cycles. When the timer expires the block pulses a delayed re-service request once. While a delay is pending, a later storm keeps the earlier deadline. A software write to a pin's entry clears that pin's counter.

Top module: `eoi_storm_ctl`

## Requirements
- R1: In the cycle after `eoi_valid`, `rirr_clear[i]` is 1 exactly for the pins with `entry_level[i]`=1, `entry_rirr[i]`=1, and vector field `entry_vector[i*VEC_W +: VEC_W]` equal to `eoi_vector`. The strobe is 0 at every other time.
- R2: A pin that fails the match of R1, including a level pin with a matching vector whose remote IRR is already clear, keeps its reassert counter unchanged.
- R3: For a matched pin with `entry_masked[i]`=0 and `irr[i]`=1, the counter increments. Any other matched pin has its counter set to 0.
- R4: If any pin's incremented counter is below `STORM_LIMIT`, `reservice_req` is 1 for the one cycle after the EOI cycle.
- R5: A pin whose incremented counter reaches `STORM_LIMIT` has its counter set to 0. It does not cause `reservice_req`, and it starts the delay timer.
- R6: `delayed_req` is 1 for exactly one cycle, `DELAY_CYCLES` clock edges after the edge that started the timer. `DELAY_CYCLES` defaults to `CLK_HZ/100`.
- R7: A storm that arrives while a delay is pending leaves the pending deadline unchanged. A storm in the same cycle as an expiry starts a new delay.
- R8: `cfg_write[i]`=1 sets pin i's counter to 0.
- R9: `done` is 1 for one cycle, one cycle after the `rirr_clear` strobes of each EOI.
- R10: After reset, `rirr_clear`, `reservice_req`, `delayed_req` and `done` are 0, and all counters and the timer are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_valid | input | 1 | EOI event this cycle |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| entry_vector | input | NUM_PINS*VEC_W | Vector field of every entry, pin i at bits i*VEC_W |
| entry_level | input | NUM_PINS | Trigger mode per pin, 1 = level |
| entry_masked | input | NUM_PINS | Mask bit per pin |
| entry_rirr | input | NUM_PINS | Remote IRR flag per pin |
| irr | input | NUM_PINS | Raw pending-request bit per pin |
| cfg_write | input | NUM_PINS | Software write strobe per pin entry |
| rirr_clear | output | NUM_PINS | Remote-IRR clear strobes |
| reservice_req | output | 1 | Immediate re-service request |
| delayed_req | output | 1 | Re-service request at timer expiry |
| done | output | 1 | EOI processing complete |

## Verification
The assertions take it for granted that `eoi_valid` is never high in two cycles back to back, so that `done` follows each EOI on its own. They also assume `DELAY_CYCLES` is at least 2, so that a delayed pulse can never run into the next one. The stimulus keeps to these: every EOI is followed by at least one idle cycle, and entry writes and EOIs are issued in separate cycles. The sweep changes the entry fields and the EOI vector arithmetically, and it adds directed runs that drive a single pin into repeated storms while a delay is still pending.

// File: rtl/eoi_storm_ctl.sv
module eoi_storm_ctl #(
  parameter int NUM_PINS     = 24,
  parameter int VEC_W        = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int CLK_HZ       = 100_000_000,
  parameter int DELAY_CYCLES = CLK_HZ / 100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic [NUM_PINS*VEC_W-1:0] entry_vector,
  input  logic [NUM_PINS-1:0]       entry_level,
  input  logic [NUM_PINS-1:0]       entry_masked,
  input  logic [NUM_PINS-1:0]       entry_rirr,
  input  logic [NUM_PINS-1:0]       irr,
  input  logic [NUM_PINS-1:0]       cfg_write,
  output logic [NUM_PINS-1:0]       rirr_clear,
  output logic                      reservice_req,
  output logic                      delayed_req,
  output logic                      done
);
  localparam int CW = $clog2(STORM_LIMIT + 1);
  localparam int TW = $clog2(DELAY_CYCLES + 1);

  logic [NUM_PINS-1:0] hit, bump, storm_v, imm_v;
  logic [CW-1:0]       cnt [NUM_PINS];
  logic                eoi_d, pending, expire, storm_any;
  logic [TW-1:0]       remain;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [CW-1:0] nxt;
    assign hit[i]     = eoi_valid && entry_level[i] && entry_rirr[i] &&
                        (entry_vector[i*VEC_W +: VEC_W] == eoi_vector);
    assign bump[i]    = hit[i] && !entry_masked[i] && irr[i];
    assign nxt        = cnt[i] + 1'b1;
    assign storm_v[i] = bump[i] && (nxt >= CW'(STORM_LIMIT));
    assign imm_v[i]   = bump[i] && !storm_v[i];

    always_ff @(posedge clk) begin
      if (!rst_n)            cnt[i] <= '0;
      else if (cfg_write[i]) cnt[i] <= '0;
      else if (hit[i])       cnt[i] <= imm_v[i] ? nxt : '0;
    end

    assert_cnt_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[i] < CW'(STORM_LIMIT));
    assert_clear_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rirr_clear[i] |-> $past(eoi_valid && entry_level[i] && entry_rirr[i]));
    assert_write_clears_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_write[i] |=> cnt[i] == '0);
  end

  assign storm_any = |storm_v;
  assign expire    = pending && (remain == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rirr_clear    <= '0;
      reservice_req <= 1'b0;
      delayed_req   <= 1'b0;
      eoi_d         <= 1'b0;
      done          <= 1'b0;
      pending       <= 1'b0;
      remain        <= '0;
    end else begin
      rirr_clear    <= hit;
      reservice_req <= |imm_v;
      eoi_d         <= eoi_valid;
      done          <= eoi_d;
      delayed_req   <= expire;
      if (storm_any && (!pending || expire)) begin
        pending <= 1'b1;
        remain  <= TW'(DELAY_CYCLES);
      end else if (expire) begin
        pending <= 1'b0;
      end else if (pending) begin
        remain  <= remain - 1'b1;
      end
    end
  end

  assert_reservice_after_eoi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reservice_req |-> $past(eoi_valid));
  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |=> ##1 done);
  assert_delayed_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    delayed_req |=> !delayed_req);
  assert_pending_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !expire && storm_any) |=> pending && remain == $past(remain) - 1'b1);
endmodule

// File: tb/tb_eoi_storm_ctl.sv
module tb_eoi_storm_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int VW  = 3;
  localparam int LIM = 3;
  localparam int DLY = 9;

  logic clk = 0, rst_n = 0, eoi_valid = 0;
  logic [VW-1:0]    eoi_vector = '0;
  logic [NP*VW-1:0] entry_vector = '0;
  logic [NP-1:0]    entry_level = '0, entry_masked = '0, entry_rirr = '0, irr = '0, cfg_write = '0;
  logic [NP-1:0]    rirr_clear;
  logic reservice_req, delayed_req, done;

  int checks = 0, failures = 0;
  bit finished = 0;
  int ecnt [NP];
  bit pend = 0;
  int rem = 0;

  eoi_storm_ctl #(.NUM_PINS(NP), .VEC_W(VW), .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .entry_vector(entry_vector), .entry_level(entry_level), .entry_masked(entry_masked),
    .entry_rirr(entry_rirr), .irr(irr), .cfg_write(cfg_write), .rirr_clear(rirr_clear),
    .reservice_req(reservice_req), .delayed_req(delayed_req), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input bit storm);
    bit exp_fire = pend && rem == 1;
    if (storm && (!pend || exp_fire)) begin pend = 1; rem = DLY; end
    else if (exp_fire) pend = 0;
    else if (pend) rem--;
    @(posedge clk); #1;
    chk(delayed_req == exp_fire, "R6/R7 delayed_req", delayed_req, exp_fire);
  endtask

  task automatic do_eoi(input logic [VW-1:0] v, input string tag);
    logic [NP-1:0] exp_clr = '0;
    bit exp_imm = 0, storm = 0;
    for (int i = 0; i < NP; i++) begin
      if (entry_level[i] && entry_rirr[i] && entry_vector[i*VW +: VW] == v) begin
        exp_clr[i] = 1;
        if (!entry_masked[i] && irr[i]) begin
          if (ecnt[i] + 1 >= LIM) begin storm = 1; ecnt[i] = 0; end
          else begin exp_imm = 1; ecnt[i]++; end
        end else ecnt[i] = 0;
      end
    end
    eoi_vector = v; eoi_valid = 1;
    tick(storm);
    chk(rirr_clear == exp_clr, {"R1/R2 rirr_clear ", tag}, rirr_clear, exp_clr);
    chk(reservice_req == exp_imm, {"R3/R4/R5 reservice_req ", tag}, reservice_req, exp_imm);
    eoi_valid = 0;
    tick(0);
    chk(done == 1, {"R9 done ", tag}, done, 1);
    chk(rirr_clear == 0, {"R1 strobe width ", tag}, rirr_clear, 0);
  endtask

  task automatic wr(input int pin);
    cfg_write = NP'(1) << pin;
    ecnt[pin] = 0;
    tick(0);
    cfg_write = '0;
  endtask

  task automatic hot_pin0(input logic [VW-1:0] v);
    entry_vector = '0; entry_vector[VW-1:0] = v;
    entry_level = 4'b0001; entry_rirr = 4'b0001; entry_masked = '0; irr = 4'b0001;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) ecnt[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(rirr_clear == 0 && !reservice_req && !delayed_req && !done, "R10 reset outputs",
        {rirr_clear, reservice_req, delayed_req, done}, 0);
    rst_n = 1;
    tick(0);
    chk(done == 0 && rirr_clear == 0, "R10 idle after reset", {rirr_clear, done}, 0);

    // Directed storm: pin 0 kept hot, storms every LIM EOIs, some while pending
    hot_pin0(3'd5);
    for (int k = 0; k < 12; k++) do_eoi(3'd5, "storm R5 R7");
    for (int k = 0; k < DLY + 2; k++) tick(0);

    // Skip with remote IRR clear keeps count (R2), then write clears count (R8)
    do_eoi(3'd5, "pre R2");
    entry_rirr = '0;
    do_eoi(3'd5, "skip R2");
    entry_rirr = 4'b0001;
    do_eoi(3'd5, "after skip R2");
    do_eoi(3'd5, "storm after skip R2");
    do_eoi(3'd5, "pre R8");
    do_eoi(3'd5, "pre R8");
    wr(0);
    do_eoi(3'd5, "after write R8");
    do_eoi(3'd5, "after write R8");
    do_eoi(3'd5, "storm after write R8");
    irr = '0;
    do_eoi(3'd5, "irr low R3");
    for (int k = 0; k < DLY + 2; k++) tick(0);

    // Arithmetic sweep over entry fields and vectors
    for (int p = 0; p < 600; p++) begin
      int w = (p * 40503 + 7) & 16'hffff;
      for (int i = 0; i < NP; i++) entry_vector[i*VW +: VW] = VW'((i*3 + p) & 7);
      entry_level  = NP'(w);
      entry_rirr   = NP'(w >> 4) | NP'(p);
      entry_masked = NP'(w >> 8) & NP'(w >> 12);
      irr          = NP'(w >> 12) | NP'(w >> 2);
      if (p % 17 == 0) wr(p % NP);
      do_eoi(VW'((p * 5) & 7), "sweep");
      for (int k = 0; k < (p % 4); k++) tick(0);
    end
    for (int k = 0; k < DLY + 2; k++) tick(0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule